// File: doc/BRIEF.md
# Video Memory CPU Port Slot Scheduler

This block sits between a CPU and the two memories of a video processor: a 16 KiB video RAM and a 32-entry palette RAM. The CPU sets a write address with two bytes on the control port, then streams bytes into the data port. Each data byte waits in a one-byte holding register. It goes into memory only at an access slot, and the slot timing comes from the raster position.

On blanked lines a slot comes every 4 pixel positions. On active display lines a slot comes only every 32 pixel positions, so a CPU that writes faster than that loses bytes. The port has no back-pressure. A byte that is still held when the next one arrives is overwritten, and a sticky flag records the loss until software clears it. After each committed byte the address steps forward and wraps inside the selected memory.

The clock runs at the pixel rate, so the horizontal position advances by one each cycle. A line has 342 positions, and lines at or above the active-line count are blanked.

Top module: `vidMemPortSched`

## Requirements
- R1: After reset `memWrEn` and `overflow` are 0, and no memory write happens until a data-port byte has been written.
- R2: On a blanked line (`vPos` >= 192) a held byte is committed only at a position with `hPos` a multiple of 4. `memWrEn` pulses in the cycle after that slot position was presented.
- R3: On an active line (`vPos` < 192) a held byte is committed only at a position with `hPos` a multiple of 32, and never at any other position of the line.
- R4: A data-port write that arrives while an earlier byte is still held and not being committed replaces that byte. Only the later byte reaches memory.
- R5: `overflow` goes to 1 when a held byte is replaced and stays 1 until a cycle with `ovfClr` high and no replacing write. If a replacement and `ovfClr` coincide, the flag is set.
- R6: The address comes from two control-port bytes, low byte first. The second byte gives address bits 13:8 in its bits 5:0 and the target in bit 7 (0 = video RAM, 1 = palette). The load takes effect at once, without waiting for a slot, and a byte still held commits to the newly loaded address.
- R7: After each committed byte the address increments by one. A video RAM address wraps from 0x3FFF to 0x0000.
- R8: With the palette selected, the loaded address is reduced to its low 5 bits, and increments wrap from 0x1F to 0x00.
- R9: Each held byte produces exactly one single-cycle `memWrEn` pulse, carrying that byte, the address and the target in force at its slot.
- R10: A data write in the same cycle as a slot that commits the held byte is not a loss. The held byte is committed, the new byte becomes held, and `overflow` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| dataWr | input | 1 | Data-port write strobe |
| dataIn | input | 8 | Data-port byte |
| ctrlWr | input | 1 | Control-port write strobe |
| ctrlIn | input | 8 | Control-port byte |
| ovfClr | input | 1 | Clear strobe for the overflow flag |
| hPos | input | 9 | Horizontal pixel position, 0 to 341 |
| vPos | input | 9 | Line number |
| memWrEn | output | 1 | One-cycle memory write command |
| memSel | output | 1 | Write target: 0 video RAM, 1 palette RAM |
| memAddr | output | 14 | Write address |
| memData | output | 8 | Write data |
| overflow | output | 1 | Sticky flag for a lost data byte |

## Verification
The bench fixes the cycle of each data write against the slot grid. It places a write exactly on a slot while a byte is held, which catches a design that counts this as a loss or drops one of the two bytes. It places two writes inside one 32-position active gap, which catches a design that commits both bytes or forgets to set the flag. It also pulses the clear strobe in the same cycle as an overwrite, which catches a design where clearing wins.

The bench reloads the address while a byte is held, which exposes a design that defers the load to a slot or commits to the old address. It runs the address through the 0x3FFF and palette 0x1F wrap points, where a missing mask shows up as writes past the end of the memory.

// File: rtl/vidMemPortPkg.sv
package vidMemPortPkg;

  typedef enum logic {
    TGT_VRAM = 1'b0,
    TGT_PAL  = 1'b1
  } memTarget_e;

  // Per-cycle commands from the slot control to the datapath
  typedef struct packed {
    logic commit;     // held byte goes to memory this cycle
    logic capture;    // new data byte enters the holding register
    logic overwrite;  // a held byte is being replaced before its slot
    logic loadLow;    // first control byte
    logic loadHigh;   // second control byte
    logic clearOvf;   // clear request for the loss flag
  } portStrobes_t;

endpackage

// File: rtl/vidMemSlotCtrl.sv
module vidMemSlotCtrl
  import vidMemPortPkg::*;
#(
  parameter int H_W          = 9,
  parameter int V_W          = 9,
  parameter int LINE_PIXELS  = 342,
  parameter int ACTIVE_LINES = 192,
  parameter int ACTIVE_LOG2  = 5,
  parameter int BLANK_LOG2   = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           dataWr,
  input  logic           ctrlWr,
  input  logic           ovfClr,
  input  logic [H_W-1:0] hPos,
  input  logic [V_W-1:0] vPos,
  output portStrobes_t   strobes
);

  localparam logic [H_W-1:0] LINE_END = H_W'(LINE_PIXELS);
  localparam logic [V_W-1:0] ACT_END  = V_W'(ACTIVE_LINES);

  logic activeLine;
  logic inLine;
  logic activeSlot;
  logic blankSlot;
  logic slotHit;
  logic pendingQ;
  logic phaseQ;   // 0: expecting low byte, 1: expecting high byte

  assign activeLine = (vPos < ACT_END);
  assign inLine     = (hPos < LINE_END);

  // Slot spacing variants: a zero log2 spacing means every position is a slot
  generate
    if (ACTIVE_LOG2 == 0) begin : gActAll
      assign activeSlot = 1'b1;
    end else begin : gActGrid
      assign activeSlot = (hPos[ACTIVE_LOG2-1:0] == '0);
    end
    if (BLANK_LOG2 == 0) begin : gBlkAll
      assign blankSlot = 1'b1;
    end else begin : gBlkGrid
      assign blankSlot = (hPos[BLANK_LOG2-1:0] == '0);
    end
  endgenerate

  assign slotHit = inLine && (activeLine ? activeSlot : blankSlot);

  always_comb begin
    strobes           = '0;
    strobes.commit    = slotHit && pendingQ;
    strobes.capture   = dataWr;
    strobes.overwrite = dataWr && pendingQ && !(slotHit && pendingQ);
    strobes.loadLow   = ctrlWr && !phaseQ;
    strobes.loadHigh  = ctrlWr && phaseQ;
    strobes.clearOvf  = ovfClr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendingQ <= 1'b0;
      phaseQ   <= 1'b0;
    end else begin
      if (dataWr) begin
        pendingQ <= 1'b1;
      end else if (slotHit) begin
        pendingQ <= 1'b0;
      end
      if (ctrlWr) begin
        phaseQ <= !phaseQ;
      end
    end
  end

endmodule

// File: rtl/vidMemPortPath.sv
module vidMemPortPath
  import vidMemPortPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int VRAM_AW = 14,
  parameter int PAL_AW  = 5,
  parameter int SEL_BIT = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  portStrobes_t       strobes,
  input  logic [DATA_W-1:0]  dataIn,
  input  logic [DATA_W-1:0]  ctrlIn,
  output logic               memWrEn,
  output logic               memSel,
  output logic [VRAM_AW-1:0] memAddr,
  output logic [DATA_W-1:0]  memData,
  output logic               overflow
);

  localparam int HI_W = VRAM_AW - DATA_W;
  localparam logic [VRAM_AW-1:0] PAL_MASK = VRAM_AW'((1 << PAL_AW) - 1);

  logic [DATA_W-1:0]  holdQ;
  logic [DATA_W-1:0]  lowQ;
  logic [VRAM_AW-1:0] addrQ;
  memTarget_e         tgtQ;
  logic               ovfQ;

  logic [VRAM_AW-1:0] loadAddr;
  memTarget_e         loadTgt;
  logic [VRAM_AW-1:0] incAddr;

  always_comb begin
    loadTgt  = memTarget_e'(ctrlIn[SEL_BIT]);
    loadAddr = {ctrlIn[HI_W-1:0], lowQ};
    if (loadTgt == TGT_PAL) begin
      loadAddr = loadAddr & PAL_MASK;
    end
    incAddr = addrQ + 1'b1;
    if (tgtQ == TGT_PAL) begin
      incAddr = incAddr & PAL_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdQ   <= '0;
      lowQ    <= '0;
      addrQ   <= '0;
      tgtQ    <= TGT_VRAM;
      ovfQ    <= 1'b0;
      memWrEn <= 1'b0;
      memSel  <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      memWrEn <= strobes.commit;
      if (strobes.commit) begin
        memSel  <= (tgtQ == TGT_PAL);
        memAddr <= addrQ;
        memData <= holdQ;
      end
      if (strobes.capture) begin
        holdQ <= dataIn;
      end
      if (strobes.loadLow) begin
        lowQ <= ctrlIn;
      end
      if (strobes.loadHigh) begin
        addrQ <= loadAddr;
        tgtQ  <= loadTgt;
      end else if (strobes.commit) begin
        addrQ <= incAddr;
      end
      if (strobes.overwrite) begin
        ovfQ <= 1'b1;
      end else if (strobes.clearOvf) begin
        ovfQ <= 1'b0;
      end
    end
  end

  assign overflow = ovfQ;

endmodule

// File: rtl/vidMemPortSched.sv
module vidMemPortSched
  import vidMemPortPkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int VRAM_AW      = 14,
  parameter int PAL_AW       = 5,
  parameter int H_W          = 9,
  parameter int V_W          = 9,
  parameter int LINE_PIXELS  = 342,
  parameter int ACTIVE_LINES = 192,
  parameter int ACTIVE_LOG2  = 5,
  parameter int BLANK_LOG2   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dataWr,
  input  logic [DATA_W-1:0]  dataIn,
  input  logic               ctrlWr,
  input  logic [DATA_W-1:0]  ctrlIn,
  input  logic               ovfClr,
  input  logic [H_W-1:0]     hPos,
  input  logic [V_W-1:0]     vPos,
  output logic               memWrEn,
  output logic               memSel,
  output logic [VRAM_AW-1:0] memAddr,
  output logic [DATA_W-1:0]  memData,
  output logic               overflow
);

  portStrobes_t strobes;

  vidMemSlotCtrl #(
    .H_W          (H_W),
    .V_W          (V_W),
    .LINE_PIXELS  (LINE_PIXELS),
    .ACTIVE_LINES (ACTIVE_LINES),
    .ACTIVE_LOG2  (ACTIVE_LOG2),
    .BLANK_LOG2   (BLANK_LOG2)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .dataWr  (dataWr),
    .ctrlWr  (ctrlWr),
    .ovfClr  (ovfClr),
    .hPos    (hPos),
    .vPos    (vPos),
    .strobes (strobes)
  );

  vidMemPortPath #(
    .DATA_W  (DATA_W),
    .VRAM_AW (VRAM_AW),
    .PAL_AW  (PAL_AW),
    .SEL_BIT (DATA_W - 1)
  ) u_path (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .dataIn   (dataIn),
    .ctrlIn   (ctrlIn),
    .memWrEn  (memWrEn),
    .memSel   (memSel),
    .memAddr  (memAddr),
    .memData  (memData),
    .overflow (overflow)
  );

endmodule

// File: rtl/vidMemPortChk.sv
module vidMemPortChk #(
  parameter int VRAM_AW      = 14,
  parameter int PAL_AW       = 5,
  parameter int H_W          = 9,
  parameter int V_W          = 9,
  parameter int ACTIVE_LINES = 192,
  parameter int ACTIVE_LOG2  = 5,
  parameter int BLANK_LOG2   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               dataWr,
  input logic               ctrlWr,
  input logic               ovfClr,
  input logic [H_W-1:0]     hPos,
  input logic [V_W-1:0]     vPos,
  input logic               memWrEn,
  input logic               memSel,
  input logic [VRAM_AW-1:0] memAddr,
  input logic               overflow
);

  localparam logic [V_W-1:0] ACT_END = V_W'(ACTIVE_LINES);
  localparam logic [H_W-1:0] ACT_M   = H_W'((1 << ACTIVE_LOG2) - 1);
  localparam logic [H_W-1:0] BLK_M   = H_W'((1 << BLANK_LOG2) - 1);
  localparam logic [VRAM_AW-1:0] PAL_MASK = VRAM_AW'((1 << PAL_AW) - 1);

  logic               lastValid;
  logic               lastSel;
  logic [VRAM_AW-1:0] lastAddr;
  logic               ctrlSeen;
  logic [VRAM_AW-1:0] nextAddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      lastValid <= 1'b0;
      lastSel   <= 1'b0;
      lastAddr  <= '0;
      ctrlSeen  <= 1'b0;
    end else begin
      if (memWrEn) begin
        lastValid <= 1'b1;
        lastSel   <= memSel;
        lastAddr  <= memAddr;
      end
      if (ctrlWr) begin
        ctrlSeen <= 1'b1;
      end else if (memWrEn) begin
        ctrlSeen <= 1'b0;
      end
    end
  end

  assign nextAddr = lastSel ? ((lastAddr + 1'b1) & PAL_MASK) : (lastAddr + 1'b1);

  // R3
  active_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (memWrEn && ($past(vPos) < ACT_END)) |-> (($past(hPos) & ACT_M) == '0));

  // R2
  blank_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (memWrEn && ($past(vPos) >= ACT_END)) |-> (($past(hPos) & BLK_M) == '0));

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    memWrEn |=> !memWrEn);

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overflow && !ovfClr) |=> overflow);

  // R5
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(dataWr));

  // R5
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ovfClr && !dataWr) |=> !overflow);

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (memWrEn && lastValid && !ctrlSeen) |-> (memAddr == nextAddr && memSel == lastSel));

  // R8
  pal_range_chk: assert property (@(posedge clk) disable iff (rst)
    (memWrEn && memSel) |-> ((memAddr & ~PAL_MASK) == '0));

endmodule

bind vidMemPortSched vidMemPortChk #(
  .VRAM_AW      (VRAM_AW),
  .PAL_AW       (PAL_AW),
  .H_W          (H_W),
  .V_W          (V_W),
  .ACTIVE_LINES (ACTIVE_LINES),
  .ACTIVE_LOG2  (ACTIVE_LOG2),
  .BLANK_LOG2   (BLANK_LOG2)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .dataWr   (dataWr),
  .ctrlWr   (ctrlWr),
  .ovfClr   (ovfClr),
  .hPos     (hPos),
  .vPos     (vPos),
  .memWrEn  (memWrEn),
  .memSel   (memSel),
  .memAddr  (memAddr),
  .overflow (overflow)
);

// File: tb/test_vidMemPortSched.sv
`timescale 1ns/1ps
module test_vidMemPortSched;

  localparam int LINE_PIXELS  = 342;
  localparam int ACTIVE_LINES = 192;
  localparam int LINES        = 262;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dataWr = 1'b0;
  logic [7:0]  dataIn = '0;
  logic        ctrlWr = 1'b0;
  logic [7:0]  ctrlIn = '0;
  logic        ovfClr = 1'b0;
  logic [8:0]  hPos = '0;
  logic [8:0]  vPos = '0;
  logic        memWrEn;
  logic        memSel;
  logic [13:0] memAddr;
  logic [7:0]  memData;
  logic        overflow;

  always #2 clk = ~clk;

  vidMemPortSched i_vidMemPortSched (
    .clk(clk), .rst(rst), .dataWr(dataWr), .dataIn(dataIn),
    .ctrlWr(ctrlWr), .ctrlIn(ctrlIn), .ovfClr(ovfClr),
    .hPos(hPos), .vPos(vPos), .memWrEn(memWrEn), .memSel(memSel),
    .memAddr(memAddr), .memData(memData), .overflow(overflow)
  );

  // Raster generator with a jump facility
  logic       jumpEn = 1'b0;
  logic [8:0] jumpH = '0;
  logic [8:0] jumpV = '0;
  logic [8:0] prevH = '0;
  logic [8:0] prevV = '0;

  always @(posedge clk) begin
    prevH <= hPos;
    prevV <= vPos;
    if (jumpEn) begin
      hPos <= jumpH;
      vPos <= jumpV;
    end else if (hPos == 9'(LINE_PIXELS - 1)) begin
      hPos <= '0;
      vPos <= (vPos == 9'(LINES - 1)) ? '0 : vPos + 1'b1;
    end else begin
      hPos <= hPos + 1'b1;
    end
  end

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [22:0] expQ[$];
  string       tagQ[$];
  bit          lastWr = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: compares every memory write against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (memWrEn) begin
        if (prevV < 9'(ACTIVE_LINES))
          chk((prevH % 32) == 0, "R3", "active slot position", prevH, (prevH / 32) * 32);
        else
          chk((prevH % 4) == 0, "R2", "blank slot position", prevH, (prevH / 4) * 4);
        chk(!lastWr, "R9", "back-to-back write pulse", 1, 0);
        if (expQ.size() == 0) begin
          chk(1'b0, "R9", "unexpected write", {memSel, memAddr, memData}, 0);
        end else begin
          logic [22:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk({memSel, memAddr, memData} == e, t, "write content", {memSel, memAddr, memData}, e);
        end
      end
      lastWr = memWrEn;
    end
  end

  task automatic expectWr(input bit sel, input logic [13:0] a, input logic [7:0] d, input string t);
    expQ.push_back({sel, a, d});
    tagQ.push_back(t);
  endtask

  task automatic jump(input int h, input int v);
    @(negedge clk);
    jumpEn = 1'b1; jumpH = 9'(h); jumpV = 9'(v);
    @(negedge clk);
    jumpEn = 1'b0;
  endtask

  task automatic ctrlWrite(input logic [7:0] b);
    @(negedge clk);
    ctrlWr = 1'b1; ctrlIn = b;
    @(negedge clk);
    ctrlWr = 1'b0;
  endtask

  task automatic setAddr(input bit sel, input logic [13:0] a);
    ctrlWrite(a[7:0]);
    ctrlWrite({sel, 1'b0, a[13:8]});
  endtask

  task automatic dataWrite(input logic [7:0] b);
    @(negedge clk);
    dataWr = 1'b1; dataIn = b;
    @(negedge clk);
    dataWr = 1'b0;
  endtask

  task automatic dataWriteAt(input int h, input logic [7:0] b);
    do @(negedge clk); while (hPos != 9'(h));
    dataWr = 1'b1; dataIn = b;
    @(negedge clk);
    dataWr = 1'b0;
  endtask

  task automatic drain(input string t);
    int n = 0;
    while (expQ.size() != 0 && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(expQ.size() == 0, t, "writes still outstanding", expQ.size(), 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(memWrEn == 1'b0, "R1", "write enable in reset", memWrEn, 0);
    chk(overflow == 1'b0, "R1", "overflow in reset", overflow, 0);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    chk(memWrEn == 1'b0, "R1", "idle write enable", memWrEn, 0);

    // R6 / R7 on a blanked line
    jump(0, 200);
    setAddr(1'b0, 14'h1234);
    expectWr(1'b0, 14'h1234, 8'hA5, "R6");
    dataWrite(8'hA5);
    drain("R2");
    expectWr(1'b0, 14'h1235, 8'h5A, "R7");
    dataWrite(8'h5A);
    drain("R7");

    // R3: active line, next slot at 64
    jump(40, 10);
    expectWr(1'b0, 14'h1236, 8'h11, "R3");
    dataWrite(8'h11);
    drain("R3");

    // R4 / R5: two writes inside one active gap
    jump(70, 10);
    setAddr(1'b0, 14'h0100);
    dataWrite(8'h21);
    dataWrite(8'h22);
    expectWr(1'b0, 14'h0100, 8'h22, "R4");
    drain("R4");
    chk(overflow == 1'b1, "R5", "flag after loss", overflow, 1);
    repeat (10) @(negedge clk);
    chk(overflow == 1'b1, "R5", "flag sticky", overflow, 1);
    @(negedge clk); ovfClr = 1'b1;
    @(negedge clk); ovfClr = 1'b0;
    chk(overflow == 1'b0, "R5", "flag cleared", overflow, 0);

    // R5: set wins over clear
    jump(70, 10);
    dataWrite(8'h31);
    @(negedge clk); dataWr = 1'b1; dataIn = 8'h32; ovfClr = 1'b1;
    @(negedge clk); dataWr = 1'b0; ovfClr = 1'b0;
    chk(overflow == 1'b1, "R5", "set wins over clear", overflow, 1);
    expectWr(1'b0, 14'h0101, 8'h32, "R4");
    drain("R4");
    @(negedge clk); ovfClr = 1'b1;
    @(negedge clk); ovfClr = 1'b0;

    // R10: write exactly on a committing slot
    setAddr(1'b0, 14'h2000);
    jump(0, 200);
    expectWr(1'b0, 14'h2000, 8'h41, "R10");
    expectWr(1'b0, 14'h2001, 8'h42, "R10");
    dataWriteAt(2, 8'h41);
    dataWriteAt(4, 8'h42);
    drain("R10");
    chk(overflow == 1'b0, "R10", "no loss on slot write", overflow, 0);

    // R7: video RAM wrap
    setAddr(1'b0, 14'h3FFF);
    expectWr(1'b0, 14'h3FFF, 8'h61, "R7");
    dataWrite(8'h61);
    drain("R7");
    expectWr(1'b0, 14'h0000, 8'h62, "R7");
    dataWrite(8'h62);
    drain("R7");

    // R8: palette wrap and mask
    setAddr(1'b1, 14'h001E);
    for (int i = 0; i < 3; i++) begin
      expectWr(1'b1, 14'((30 + i) % 32), 8'(8'h80 + i), "R8");
      dataWrite(8'(8'h80 + i));
      drain("R8");
    end
    setAddr(1'b1, 14'h3FFF);
    expectWr(1'b1, 14'h001F, 8'h90, "R8");
    dataWrite(8'h90);
    drain("R8");

    // R6: reload while a byte is held on an active line
    jump(33, 10);
    dataWrite(8'h71);
    setAddr(1'b0, 14'h0555);
    expectWr(1'b0, 14'h0555, 8'h71, "R6");
    drain("R6");
    chk(overflow == 1'b0, "R6", "no loss from reload", overflow, 0);

    repeat (20) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule